// File: doc/BRIEF.md
# Daisy-Chainable SPI Register Slave

This block is the serial control port of an output-switch controller. A host talks to it over a four-wire SPI link in mode 1 (clock idles low, the slave launches data on the rising clock edge, and both sides sample on the falling edge). Commands are 16-bit words. When chip select falls, the block takes a snapshot of a status word and shifts it out most-significant bit first while the new command shifts in. Once the first 16 bits have gone out, SO repeats whatever arrived on SI sixteen clocks earlier. Several devices can therefore share one chain, and the host can read its own message back.

When chip select rises, the block counts the bits it received. It commits only if the count is a nonzero multiple of 16. In that case the last 16 bits received form the command: it is decoded, the addressed register is written, and the command's watchdog bit and address field are kept for the next status word. A transfer of any other length leaves every piece of state untouched. All serial pins are oversampled and synchronised to the system clock, so the system clock must run several times faster than SCLK.

Command layout: bit 15 is the watchdog bit, bits 14:13 are don't-care, bits 12:8 are the address, and bits 7:0 are data. Status layout: bit 15 is the previous watchdog bit, bit 14 is undervoltage, bit 13 is overvoltage, bits 12:8 are the previous address, bits 7:4 are the channel faults, and bits 3:0 are the selected register nibble.

Top module: `spisw_top`

## Requirements
- R1: The status word is captured on the falling edge of chip select. SO presents bit 15 first and moves to the next bit on each rising SCLK edge. SI is sampled on each falling SCLK edge.
- R2: Every bit on SO after the first 16 equals the bit received on SI 16 SCLK cycles earlier.
- R3: On the rising edge of chip select, a commit happens only if the falling-SCLK count since chip select fell is a nonzero multiple of 16. The command is the last 16 bits received. A transfer with zero clocks commits nothing.
- R4: After a transfer whose length is invalid, registers, the write port and the next status word are the same as if that transfer had not occurred.
- R5: `so_oe` is 0 whenever the synchronised chip select is high. No write strobe occurs while `so_oe` is 1.
- R6: Status bit 15 and bits 12:8 return the watchdog bit and the 5-bit address of the last committed command.
- R7: Status bit 14 (undervoltage) and bit 13 (overvoltage) are sticky flags. A flag is cleared by a committed transfer that reported it as 1. An event in the commit cycle itself keeps the flag set.
- R8: Status bits 7:4 equal `ch_fault[3:0]` as sampled when chip select fell.
- R9: Status bits 3:0 are chosen by the 2-bit select register: 0 gives `ch_enable`, 1 gives `cfg_reg[3:0]`, 2 gives `cfg_reg[7:4]`, 3 gives `{2'b00, wdog_sel}`.
- R10: Address map: 1 writes the select register from data[1:0], 2 writes `ch_enable` from data[3:0], 3 writes `cfg_reg` from data[7:0], 4 writes `wdog_sel` from data[1:0]. Address 0 (no-op) and every other address write nothing. `wr_en` pulses for one cycle only for a mapped address, together with `wr_addr` and `wr_data`.
- R11: After reset, every register, the last-command fields and both flags are 0, `so_oe` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (idles low) |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad (tristate control) |
| uv_evt | input | 1 | Undervoltage event, sets the sticky flag |
| ov_evt | input | 1 | Overvoltage event, sets the sticky flag |
| ch_fault | input | 4 | Per-channel fault levels, channel 3 at bit 3 |
| wr_en | output | 1 | One-cycle write strobe for a mapped address |
| wr_addr | output | 5 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |
| ch_enable | output | 4 | Channel enable register |
| cfg_reg | output | 8 | Configuration register |
| wdog_sel | output | 2 | Watchdog timeout select register |
| wdog_bit | output | 1 | Watchdog bit of the last committed command |

## Verification
A committed transfer clears a voltage flag that it reported, and in the same system-clock cycle a new event can try to set that flag again. The bench provokes this by holding `ov_evt` high across a whole transfer, so that the event is active both when chip select falls and in the commit cycle. It then judges the outcome from the next status word, which must still show bit 13 set. A third transfer, with the event removed, must show the flag cleared.

// File: rtl/spisw_pkg.sv
package spisw_pkg;

    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int NUM_CH  = 4;
    localparam int SEL_W   = 2;
    localparam int WSEL_W  = 2;
    localparam int CNT_W   = $clog2(WORD_W);

    localparam logic [ADDR_W-1:0] A_NOP   = 5'd0;
    localparam logic [ADDR_W-1:0] A_STSEL = 5'd1;
    localparam logic [ADDR_W-1:0] A_CHEN  = 5'd2;
    localparam logic [ADDR_W-1:0] A_CFG   = 5'd3;
    localparam logic [ADDR_W-1:0] A_WDOG  = 5'd4;

    typedef struct packed {
        logic              wd;
        logic [1:0]        rsv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic              wd;
        logic              uv;
        logic              ov;
        logic [ADDR_W-1:0] addr;
        logic [NUM_CH-1:0] fault;
        logic [3:0]        nib;
    } status_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CHEN  = 2'd0,
        SEL_CFGLO = 2'd1,
        SEL_CFGHI = 2'd2,
        SEL_WDOG  = 2'd3
    } sel_e;

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a == A_STSEL) || (a == A_CHEN) || (a == A_CFG) || (a == A_WDOG);
    endfunction

    function automatic logic [3:0] pick_nibble(
        input sel_e               sel,
        input logic [NUM_CH-1:0]  chen,
        input logic [DATA_W-1:0]  cfg,
        input logic [WSEL_W-1:0]  wsel
    );
        logic [3:0] n;
        case (sel)
            SEL_CHEN:  n = chen;
            SEL_CFGLO: n = cfg[3:0];
            SEL_CFGHI: n = cfg[7:4];
            default:   n = {2'b00, wsel};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spisw_sync.sv
module spisw_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {(STAGES+1){RST_VAL[b]}};
            else     chain <= {chain[STAGES-1:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
        assign rise[b] = chain[STAGES-1] & ~chain[STAGES];
        assign fall[b] = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/spisw_shift.sv
module spisw_shift
    import spisw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_low,
    input  logic              si_s,
    input  logic [WORD_W-1:0] load_word,
    output logic              so_q,
    output logic [WORD_W-1:0] rx_word,
    output logic              commit
);
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              got_bits;
    logic              len_ok;

    assign len_ok = got_bits && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            so_q     <= 1'b0;
            cnt      <= '0;
            got_bits <= 1'b0;
        end else if (cs_fall) begin
            sr       <= load_word;
            so_q     <= load_word[WORD_W-1];
            cnt      <= '0;
            got_bits <= 1'b0;
        end else if (cs_low) begin
            if (sclk_rise) so_q <= sr[WORD_W-1];
            if (sclk_fall) begin
                sr       <= {sr[WORD_W-2:0], si_s};
                cnt      <= cnt + 1'b1;
                got_bits <= 1'b1;
            end
        end
    end

    assign rx_word = sr;
    assign commit  = cs_rise && len_ok;
endmodule

// File: rtl/spisw_regs.sv
module spisw_regs
    import spisw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  cmd_t              cmd,
    input  logic              cs_fall,
    input  logic              uv_evt,
    input  logic              ov_evt,
    input  logic [NUM_CH-1:0] ch_fault,
    output status_t           status,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [DATA_W-1:0] cfg_reg,
    output logic [WSEL_W-1:0] wdog_sel,
    output logic              wdog_bit
);
    sel_e              sel_q;
    logic [ADDR_W-1:0] last_addr;
    logic              uv_flag, ov_flag;
    logic              uv_rep, ov_rep;
    logic              unused_rsv;

    assign unused_rsv = ^cmd.rsv;

    always_comb begin
        status.wd    = wdog_bit;
        status.uv    = uv_flag;
        status.ov    = ov_flag;
        status.addr  = last_addr;
        status.fault = ch_fault;
        status.nib   = pick_nibble(sel_q, ch_enable, cfg_reg, wdog_sel);
    end

    // sticky flags: commit clears only what the snapshot reported
    always_ff @(posedge clk) begin
        if (rst) begin
            uv_flag <= 1'b0;
            ov_flag <= 1'b0;
            uv_rep  <= 1'b0;
            ov_rep  <= 1'b0;
        end else begin
            if (cs_fall) begin
                uv_rep <= uv_flag;
                ov_rep <= ov_flag;
            end
            if (commit) begin
                uv_flag <= (uv_flag & ~uv_rep) | uv_evt;
                ov_flag <= (ov_flag & ~ov_rep) | ov_evt;
            end else begin
                uv_flag <= uv_flag | uv_evt;
                ov_flag <= ov_flag | ov_evt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= SEL_CHEN;
            last_addr <= '0;
            wdog_bit  <= 1'b0;
            ch_enable <= '0;
            cfg_reg   <= '0;
            wdog_sel  <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (commit) begin
                last_addr <= cmd.addr;
                wdog_bit  <= cmd.wd;
                if (is_mapped(cmd.addr)) begin
                    wr_en   <= 1'b1;
                    wr_addr <= cmd.addr;
                    wr_data <= cmd.data;
                end
                case (cmd.addr)
                    A_STSEL: sel_q     <= sel_e'(cmd.data[SEL_W-1:0]);
                    A_CHEN:  ch_enable <= cmd.data[NUM_CH-1:0];
                    A_CFG:   cfg_reg   <= cmd.data;
                    A_WDOG:  wdog_sel  <= cmd.data[WSEL_W-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spisw_top.sv
module spisw_top
    import spisw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              uv_evt,
    input  logic              ov_evt,
    input  logic [NUM_CH-1:0] ch_fault,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [DATA_W-1:0] cfg_reg,
    output logic [WSEL_W-1:0] wdog_sel,
    output logic              wdog_bit
);
    localparam int PIN_N = 3;
    localparam int P_SCLK = 2, P_CS = 1, P_SI = 0;

    logic [PIN_N-1:0]  pin_s, pin_r, pin_f;
    logic              commit;
    logic [WORD_W-1:0] rx_word;
    status_t           status;
    logic              unused_edges;

    spisw_sync #(.N(PIN_N), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sclk, cs_n, si}),
        .dout (pin_s),
        .rise (pin_r),
        .fall (pin_f)
    );

    assign unused_edges = pin_r[P_SI] ^ pin_f[P_SI];

    spisw_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (pin_r[P_SCLK]),
        .sclk_fall (pin_f[P_SCLK]),
        .cs_fall   (pin_f[P_CS]),
        .cs_rise   (pin_r[P_CS]),
        .cs_low    (~pin_s[P_CS]),
        .si_s      (pin_s[P_SI]),
        .load_word (status),
        .so_q      (so),
        .rx_word   (rx_word),
        .commit    (commit)
    );

    spisw_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .cmd       (cmd_t'(rx_word)),
        .cs_fall   (pin_f[P_CS]),
        .uv_evt    (uv_evt),
        .ov_evt    (ov_evt),
        .ch_fault  (ch_fault),
        .status    (status),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ch_enable (ch_enable),
        .cfg_reg   (cfg_reg),
        .wdog_sel  (wdog_sel),
        .wdog_bit  (wdog_bit)
    );

    assign so_oe = ~pin_s[P_CS];
endmodule

// File: rtl/spisw_chk.sv
module spisw_chk
    import spisw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              so_oe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [DATA_W-1:0] cfg_reg,
    input logic [WSEL_W-1:0] wdog_sel
);
    assert_no_write_while_selected_R5: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> !wr_en);

    assert_write_mapped_only_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == A_STSEL || wr_addr == A_CHEN || wr_addr == A_CFG || wr_addr == A_WDOG));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_chen_only_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_enable) |-> (wr_en && wr_addr == A_CHEN));

    assert_cfg_only_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_reg) |-> (wr_en && wr_addr == A_CFG));

    assert_wsel_only_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(wdog_sel) |-> (wr_en && wr_addr == A_WDOG));
endmodule

bind spisw_top spisw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .so_oe     (so_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ch_enable (ch_enable),
    .cfg_reg   (cfg_reg),
    .wdog_sel  (wdog_sel)
);

// File: tb/sim_spisw_top.sv
`timescale 1ns/1ps
module sim_spisw_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       so, so_oe;
    logic       uv_evt = 1'b0, ov_evt = 1'b0;
    logic [3:0] ch_fault = 4'hA;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] ch_enable;
    logic [7:0] cfg_reg;
    logic [1:0] wdog_sel;
    logic       wdog_bit;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    spisw_top u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .uv_evt(uv_evt), .ov_evt(ov_evt),
        .ch_fault(ch_fault), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_enable(ch_enable), .cfg_reg(cfg_reg),
        .wdog_sel(wdog_sel), .wdog_bit(wdog_bit)
    );

    always @(negedge clk) if (!rst && wr_en) wr_cnt++;

    // {command, status expected back during that transfer}, ch_fault = A
    localparam logic [31:0] VEC [10] = '{
        {16'h0205, 16'h00A0},
        {16'h833C, 16'h02A5},
        {16'h0101, 16'h83A5},
        {16'h0102, 16'h01AC},
        {16'h0402, 16'h01A3},
        {16'h0103, 16'h04A3},
        {16'h8000, 16'h01A2},
        {16'h1FFF, 16'h80A2},
        {16'h0100, 16'h1FA2},
        {16'h0000, 16'h01A5}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] tx, input int nbits,
                        input logic [3:0] fault_mid, output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(8);
        ch_fault = fault_mid;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            si = tx[nbits-1-i];
            wait_clk(8);
            rx = {rx[30:0], so};
            sclk = 1'b0;
            wait_clk(8);
        end
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R11 reset state
        check("R11 so_oe", so_oe, 0);
        check("R11 ch_enable", ch_enable, 0);
        check("R11 cfg_reg", cfg_reg, 0);
        check("R11 wdog_sel", wdog_sel, 0);
        check("R11 wr_en", wr_en, 0);

        // table walk: R1 R6 R8 R9 R10
        for (int k = 0; k < 10; k++) begin
            xfer({16'h0, VEC[k][31:16]}, 16, 4'hA, got);
            check($sformatf("R1 R6 R9 vector %0d", k), got[15:0], VEC[k][15:0]);
        end
        check("R10 write count", wr_cnt, 7);
        check("R10 ch_enable", ch_enable, 4'h5);
        check("R10 cfg_reg", cfg_reg, 8'h3C);
        check("R10 wdog_sel", wdog_sel, 2'd2);

        // R4 invalid length (8 bits of a channel-enable write)
        xfer(32'h02, 8, 4'hA, got);
        check("R4 no write strobe", wr_cnt, 7);
        check("R4 ch_enable kept", ch_enable, 4'h5);
        xfer(32'h0000, 16, 4'hA, got);
        check("R4 status unaffected", got[15:0], 16'h00A5);

        // R3 zero-length transfer and R5 output enable
        cs_n = 1'b0;
        wait_clk(8);
        check("R5 so_oe while selected", so_oe, 1);
        cs_n = 1'b1;
        wait_clk(10);
        check("R5 so_oe after deselect", so_oe, 0);
        check("R3 zero length commits nothing", wr_cnt, 7);

        // R2 R3 R8 daisy chain: two words, fault input changes after CS falls
        ch_fault = 4'h6;
        wait_clk(4);
        xfer({16'h020F, 16'h0203}, 32, 4'h9, got);
        check("R8 first word fault snapshot", got[31:16], 16'h0065);
        check("R2 pass-through echo", got[15:0], 16'h020F);
        check("R3 last word committed", ch_enable, 4'h3);
        check("R3 one strobe for two words", wr_cnt, 8);
        xfer(32'h0000, 16, 4'h9, got);
        check("R6 after daisy", got[15:0], 16'h0293);

        // R7 undervoltage report then clear
        uv_evt = 1'b1;
        wait_clk(1);
        uv_evt = 1'b0;
        wait_clk(2);
        xfer(32'h0000, 16, 4'h9, got);
        check("R7 uv reported", got[15:0], 16'h4093);
        xfer(32'h0000, 16, 4'h9, got);
        check("R7 uv cleared", got[15:0], 16'h0093);

        // R7 overvoltage event coincident with the clearing commit
        ov_evt = 1'b1;
        wait_clk(2);
        xfer(32'h0000, 16, 4'h9, got);
        check("R7 ov reported", got[15:0], 16'h2093);
        ov_evt = 1'b0;
        wait_clk(2);
        xfer(32'h0000, 16, 4'h9, got);
        check("R7 ov survives same-cycle set", got[15:0], 16'h2093);
        xfer(32'h0000, 16, 4'h9, got);
        check("R7 ov cleared", got[15:0], 16'h0093);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule